// File: doc/BRIEF.md
# Buffered parallel-load shift register

This block turns a parallel byte into a serial bit stream through two register stages. A holding register takes a snapshot of the parallel inputs when its capture clock rises. A shift register then takes that snapshot and moves it out one bit at a time, last stage first. The shift clock, the capture clock, an active-low load strobe and an active-low clear arrive as ordinary asynchronous signals. The block samples them on a single system clock and rebuilds their behaviour from what it sees on that clock.

The load is level-sensitive. It only acts while the shift clock is low. While the shift clock is high, the load strobe is locked out. The clear empties the shift register and leaves the holding register alone. When the load and the clear are asserted together, the outcome is undefined in a real part. The block raises a flag while both are asserted, and it lets the clear win. Every pin passes through the same synchronizer depth, so data stays aligned with the control edges that go with it.

Top module: `piso_buffered`

## Requirements
- R1: After system reset (`rst_n` low), both registers hold zero, `ser_out` is 0 and `conflict` is 0.
- R2: A rising edge on `stg_clk` copies `par_in` into the holding register, whatever the levels of `sh_clk`, `load_n` and `clear_n`.
- R3: When `stg_clk` shows no rising edge, the holding register keeps its value.
- R4: While `load_n` is 0, `sh_clk` is 0 and `clear_n` is 1, the shift register follows the holding register on every system cycle. The load acts on levels, not edges.
- R5: While `sh_clk` is 1, `load_n` has no effect and the shift register keeps its value.
- R6: While `clear_n` is 0, the shift register is zero. This takes priority over load and shift. The holding register is unaffected.
- R7: A rising edge on `sh_clk`, with `load_n` and `clear_n` both 1, moves bit i of the shift register into bit i+1 and puts `ser_in` into bit 0. `ser_out` is always bit WIDTH-1 (the MSB).
- R8: `conflict` is 1 exactly while the synchronized `load_n` and `clear_n` are both 0.
- R9: With no rising edge on `sh_clk` and with `load_n` and `clear_n` both 1, the shift register holds.
- R10: A capture edge and an active load in the same system cycle load the newly captured `par_in` straight into the shift register.
- R11: An input change that is stable before system clock edge k acts on the registers at edge k+2. With `SYNC_STAGES`=2, `ser_out` shows the result after that edge. `conflict` follows after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| par_in | input | WIDTH | Parallel data byte |
| ser_in | input | 1 | Serial data shifted into bit 0 |
| stg_clk | input | 1 | Capture clock of the holding register (rising edge) |
| sh_clk | input | 1 | Shift clock (rising edge); its level gates the load |
| load_n | input | 1 | Load strobe, active low, level-sensitive |
| clear_n | input | 1 | Shift register clear, active low |
| ser_out | output | 1 | Serial output, MSB of the shift register |
| conflict | output | 1 | High while load and clear are both asserted |

## Verification
The bench loads alternating, all-ones and single-bit patterns. Each one is shifted out completely, which shows whether the bit order and the feed from `ser_in` are right, and whether any stage is stuck. A load held low while the shift clock is high is followed by a normal shift-out, which separates a correct lockout from a load that leaks through. A clear applied between a capture and a later load shows that the clear touches only the shift register. A capture edge that lands in the same cycle as a load separates pass-through from loading the stale snapshot. A behavioural model compares the outputs every cycle, so the latency through the synchronizer is checked along with the values.

// File: rtl/piso_buffered_pkg.sv
package piso_buffered_pkg;

   typedef struct packed {
      logic stg;
      logic sh;
      logic ld_n;
      logic clr_n;
   } ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(ctrl_t);
   localparam ctrl_t CTRL_IDLE = '{stg: 1'b0, sh: 1'b0, ld_n: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
   parameter int unsigned BITS   = 8,
   parameter int unsigned STAGES = 2,
   parameter logic [BITS-1:0] RST_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] din,
   output logic [BITS-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("piso_sync: STAGES must be at least 2");
   end

   logic [BITS-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/piso_store.sv
module piso_store #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [WIDTH-1:0] par_s,
   output logic [WIDTH-1:0] stg_q,
   output logic [WIDTH-1:0] stg_next
);

   assign stg_next = capture ? par_s : stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_next;
   end

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (stg_q == $past(par_s)));

   p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(stg_q));

endmodule

// File: rtl/piso_shift.sv
module piso_shift #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_act,
   input  logic             ld_act,
   input  logic             sh_lvl,
   input  logic             sh_rise,
   input  logic             ser_s,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] sr_q,
   output logic             ser_out
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] sr_d;

   always_comb begin
      sr_d = sr_q;
      if (clr_act)                  sr_d = '0;
      else if (ld_act && !sh_lvl)   sr_d = load_val;
      else if (sh_rise && !ld_act)  sr_d = {sr_q[MSB-1:0], ser_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
   end

   assign ser_out = sr_q[MSB];

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_act && !sh_lvl && !clr_act) |=> (sr_q == $past(load_val)));

   p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_lvl && !sh_rise && !clr_act) |=> $stable(sr_q));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> (sr_q == '0));

   p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_rise && !ld_act && !clr_act) |=>
         (sr_q == {$past(sr_q[MSB-1:0]), $past(ser_s)}));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_rise && !ld_act && !clr_act) |=> $stable(sr_q));

endmodule

// File: rtl/piso_buffered.sv
module piso_buffered
   import piso_buffered_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             stg_clk,
   input  logic             sh_clk,
   input  logic             load_n,
   input  logic             clear_n,
   output logic             ser_out,
   output logic             conflict
);

   localparam int unsigned BUS = WIDTH + 1 + CTRL_BITS;
   localparam logic [BUS-1:0] BUS_IDLE = {{WIDTH{1'b0}}, 1'b0, CTRL_IDLE};

   if (WIDTH < 2) begin : g_bad_width
      $error("piso_buffered: WIDTH must be at least 2");
   end

   ctrl_t            ctrl_in, ctrl_s, ctrl_prev;
   logic [WIDTH-1:0] par_s;
   logic             ser_s;
   logic [BUS-1:0]   bus_s;
   logic             stg_rise, sh_rise;
   logic [WIDTH-1:0] stg_q, stg_next, sr_q;

   assign ctrl_in = '{stg: stg_clk, sh: sh_clk, ld_n: load_n, clr_n: clear_n};

   piso_sync #(.BITS(BUS), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({par_in, ser_in, ctrl_in}),
      .dout (bus_s)
   );

   assign {par_s, ser_s, ctrl_s} = bus_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_prev <= CTRL_IDLE;
      else        ctrl_prev <= ctrl_s;
   end

   assign stg_rise = ctrl_s.stg & ~ctrl_prev.stg;
   assign sh_rise  = ctrl_s.sh  & ~ctrl_prev.sh;

   piso_store #(.WIDTH(WIDTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (stg_rise),
      .par_s   (par_s),
      .stg_q   (stg_q),
      .stg_next(stg_next)
   );

   piso_shift #(.WIDTH(WIDTH)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_act (~ctrl_s.clr_n),
      .ld_act  (~ctrl_s.ld_n),
      .sh_lvl  (ctrl_s.sh),
      .sh_rise (sh_rise),
      .ser_s   (ser_s),
      .load_val(stg_next),
      .sr_q    (sr_q),
      .ser_out (ser_out)
   );

   assign conflict = ~ctrl_s.ld_n & ~ctrl_s.clr_n;

   p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_rise && !ctrl_s.ld_n && !ctrl_s.sh && ctrl_s.clr_n) |=> (sr_q == $past(par_s)));

   p_store_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_s.clr_n && !stg_rise) |=> $stable(stg_q));

endmodule

// File: tb/piso_buffered_tb_top.sv
module piso_buffered_tb_top;

   localparam int W = 8;

   typedef struct {
      logic [W-1:0] par;
      bit ser, stg, sh, ld, clr;
   } snap_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         ser_in = 1'b0, stg_clk = 1'b0, sh_clk = 1'b0;
   logic         load_n = 1'b1, clear_n = 1'b1;
   logic         ser_out, conflict;

   int    total = 0, bad = 0, cycles = 0;
   string cur_req = "R1";

   piso_buffered #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
      .stg_clk(stg_clk), .sh_clk(sh_clk), .load_n(load_n), .clear_n(clear_n),
      .ser_out(ser_out), .conflict(conflict)
   );

   always #5 clk = ~clk;

   // behavioural model: queue of input snapshots, three-edge latency
   snap_t        hist[$];
   logic [W-1:0] m_sr, m_stg;
   bit           m_conf;

   function automatic snap_t idle_snap();
      snap_t s;
      s.par = '0; s.ser = 0; s.stg = 0; s.sh = 0; s.ld = 1; s.clr = 1;
      return s;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < 4; i++) hist.push_back(idle_snap());
         m_sr = '0; m_stg = '0; m_conf = 0;
      end else begin
         snap_t s, c, p;
         logic [W-1:0] nstg;
         s.par = par_in; s.ser = ser_in; s.stg = stg_clk; s.sh = sh_clk;
         s.ld = load_n; s.clr = clear_n;
         hist.push_front(s);
         void'(hist.pop_back());
         c = hist[2]; p = hist[3];
         nstg = (c.stg && !p.stg) ? c.par : m_stg;
         if (!c.clr)                       m_sr = '0;
         else if (!c.ld && !c.sh)          m_sr = nstg;
         else if (c.sh && !p.sh && c.ld)   m_sr = {m_sr[W-2:0], c.ser};
         m_stg = nstg;
         m_conf = !hist[1].ld && !hist[1].clr;
      end
   end

   task automatic chk(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk({cur_req, " ser_out"}, ser_out, m_sr[W-1]);
         chk({cur_req, " conflict (R8)"}, conflict, m_conf);
      end
      if (cycles > 100000) begin
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic capture(logic [W-1:0] v);
      par_in = v; wait_n(1);
      stg_clk = 1; wait_n(3);
      stg_clk = 0; wait_n(3);
   endtask

   task automatic do_load();
      load_n = 0; wait_n(4);
      load_n = 1; wait_n(4);
   endtask

   task automatic shift_bit(logic b);
      ser_in = b; wait_n(1);
      sh_clk = 1; wait_n(3);
      sh_clk = 0; wait_n(3);
   endtask

   task automatic shift_all(logic fill);
      for (int i = 0; i < W; i++) shift_bit(fill ^ i[0]);
   endtask

   initial begin
      // R1 reset state
      cur_req = "R1";
      wait_n(3);
      chk("R1 ser_out", ser_out, 1'b0);
      chk("R1 conflict", conflict, 1'b0);
      rst_n = 1; wait_n(4);
      chk("R1 ser_out after release", ser_out, 1'b0);

      // R2/R4/R7/R11 pattern A5
      cur_req = "R2";  capture(8'hA5);
      cur_req = "R4";  do_load();
      chk("R4 loaded MSB", ser_out, 1'b1);
      cur_req = "R7";  shift_all(1'b0);

      // R3 capture absent: load again gives same data; all ones then single bit
      cur_req = "R2";  capture(8'hFF);
      cur_req = "R3";  wait_n(6); do_load();
      chk("R3 kept FF", ser_out, 1'b1);
      cur_req = "R7";  shift_all(1'b0);
      cur_req = "R2";  capture(8'h01);
      cur_req = "R4";  do_load();
      chk("R4 single bit MSB", ser_out, 1'b0);
      cur_req = "R7";  shift_all(1'b1);

      // R5 lockout: sh high, load pulsed with new storage
      cur_req = "R5";
      capture(8'hC3);
      sh_clk = 1; wait_n(3);
      load_n = 0; wait_n(5); load_n = 1; wait_n(3);
      sh_clk = 0; wait_n(4);
      shift_all(1'b0);

      // R6 clear keeps storage; R2 capture during clear
      cur_req = "R6";
      capture(8'h96); do_load();
      clear_n = 0; wait_n(4);
      chk("R6 cleared", ser_out, 1'b0);
      capture(8'h81);
      clear_n = 1; wait_n(4);
      chk("R6 still clear", ser_out, 1'b0);
      do_load();
      chk("R6 storage intact", ser_out, 1'b1);
      shift_all(1'b1);

      // R8 conflict
      cur_req = "R8";
      load_n = 0; clear_n = 0; wait_n(4);
      chk("R8 flag set", conflict, 1'b1);
      chk("R8 clear wins", ser_out, 1'b0);
      load_n = 1; clear_n = 1; wait_n(4);
      chk("R8 flag drop", conflict, 1'b0);

      // R9 hold: nothing toggles
      cur_req = "R9";
      capture(8'h80); do_load();
      par_in = 8'h00; ser_in = 0; wait_n(10);
      chk("R9 held", ser_out, 1'b1);

      // R10 same-cycle capture and load
      cur_req = "R10";
      capture(8'h00); do_load();
      par_in = 8'hB7; wait_n(1);
      stg_clk = 1; load_n = 0; wait_n(3);
      chk("R10 pass-through MSB", ser_out, 1'b1);
      stg_clk = 0; load_n = 1; wait_n(3);
      shift_all(1'b0);

      // R11 latency: change at one edge, visible after third
      cur_req = "R11";
      clear_n = 0; wait_n(1);
      clear_n = 1; wait_n(6);
      do_load();

      wait_n(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule